// File: doc/BRIEF.md
# Back-EMF Stall Detector with Sticky Flag

This block decides when a stepper motor has stalled. Each time the step sequencer reaches a zero-current microstep, a sampling window of programmable length opens. When the window runs out, the digitized back-EMF value is compared with a programmable threshold. A sample below the threshold counts as a low step. When enough low steps arrive in a row, the block reports a stall. It has an active-low stall pin, a live status bit that clears itself, and a sticky status bit that stays set until software writes zero to it.

The required run length is 1, 2, 4 or 8 consecutive low steps, chosen by a 2-bit select. The detector is gated off in full-step mode, because that mode has no zero-current state. It is also gated off when external stall detection is selected. A step that arrives before its predecessor's window has finished gives no sample.

The sampling window runs on an FSM with two states. In `WIN_IDLE` it waits for an enabled step, and a step moves it to `WIN_SAMPLE` (transition *open*). In `WIN_SAMPLE` there are three possible transitions:
- When the timer runs out, it fires one sample and goes back to `WIN_IDLE` (transition *complete*).
- A new step restarts the timer and stays in `WIN_SAMPLE` (transition *restart*, an abort).
- Losing enable goes to `WIN_IDLE` (transition *gate*, also an abort).

The status FSM also has two states. `ST_CLEAR` moves to `ST_STALLED` on a detection (transition *detect*). `ST_STALLED` goes back to `ST_CLEAR` on a non-low sample (transition *release*) or when the detector is gated off (transition *gate*).

Top module: `bemf_stall_detect`

## Requirements
- R1: After synchronous reset, `stall_n` is 1, `stall_live` is 0, `stall_latched` is 0, the run count is zero and no window is open.
- R2: A sample counts as low only when `bemf` is strictly less than `thresh`. A value equal to the threshold is not low.
- R3: A stall is reported when the run of consecutive low samples reaches the target. `run_sel` 0, 1, 2 and 3 select 1, 2, 4 and 8 samples respectively.
- R4: The sample is taken at the end of the window, not at the step. With a step seen at clock edge E, the outputs change after edge E+`win_len`. A `win_len` of 0 acts as 1.
- R5: On detection, `stall_n` goes to 0, and `stall_live` and `stall_latched` both go to 1.
- R6: A completed window whose sample is not low returns `stall_n` to 1, clears `stall_live` and resets the run count.
- R7: `stall_latched` is unaffected by `stall_live` clearing and by writes of 1. It clears only on a cycle with `flag_wr`=1 and `flag_wdata`=0.
- R8: While `full_step` is 1, no stall is ever reported: `stall_n` goes to 1, `stall_live` goes to 0, any open window is dropped and the run count is reset.
- R9: While `ext_mode` is 1, the same gating as R8 applies. `stall_latched` keeps its value.
- R10: A step arriving during an open window aborts it: no sample is taken, the run count is reset and a fresh window starts from that step.
- R11: If a clear write and a detection happen in the same cycle, `stall_latched` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_step | input | 1 | One-cycle pulse marking a zero-current microstep |
| win_len | input | WIN_W (8) | Sampling window length in clock cycles |
| bemf | input | BEMF_W (8) | Digitized back-EMF value |
| thresh | input | BEMF_W (8) | Stall threshold |
| run_sel | input | 2 | Consecutive-count select (1, 2, 4, 8) |
| ext_mode | input | 1 | 1 selects external detection; the internal detector is gated off |
| full_step | input | 1 | 1 while the sequencer runs full steps; the detector is gated off |
| flag_wr | input | 1 | Write strobe for the sticky flag |
| flag_wdata | input | 1 | Write data for the sticky flag; 0 clears it |
| stall_n | output | 1 | Stall pin, active low |
| stall_live | output | 1 | Live stall status, clears itself |
| stall_latched | output | 1 | Sticky stall status |

## Verification
Some properties are checked by assertions on every cycle:
- the run count never passes eight;
- a detection only comes from a completed low sample;
- gating clears the live flag in the next cycle;
- the sticky flag falls only after a clear write, and is set whenever the live flag rises or a detection meets a clear write.

Other behaviour can only be shown by bench scenarios, checked against a behavioural reference model:
- the exact cycle at which a window completes;
- the strict comparison at the threshold;
- the run lengths for each select value;
- the counter reset after an aborted or gated window.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic {
        WIN_IDLE   = 1'b0,
        WIN_SAMPLE = 1'b1
    } win_state_t;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_STALLED = 1'b1
    } stall_state_t;

endpackage

// File: rtl/bsd_window.sv
module bsd_window
    import bsd_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             zc_step,
    input  logic [WIN_W-1:0] win_len,
    output logic             fire,
    output logic             abort,
    output logic             busy
);

    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    win_state_t       state_q, state_d;
    logic [WIN_W-1:0] timer_q, timer_d;
    logic [WIN_W-1:0] len_eff;

    assign len_eff = (win_len == '0) ? ONE : win_len;

    // next-state logic
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (enable && zc_step) begin          // open
                    state_d = WIN_SAMPLE;
                    timer_d = len_eff;
                end
            end
            WIN_SAMPLE: begin
                if (!enable) begin                    // gate
                    state_d = WIN_IDLE;
                    timer_d = '0;
                end else if (zc_step) begin           // restart
                    state_d = WIN_SAMPLE;
                    timer_d = len_eff;
                end else if (timer_q == ONE) begin    // complete
                    state_d = WIN_IDLE;
                    timer_d = '0;
                end else begin
                    timer_d = timer_q - ONE;
                end
            end
            default: begin
                state_d = WIN_IDLE;
                timer_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // outputs
    always_comb begin
        fire  = 1'b0;
        abort = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            WIN_IDLE: begin
                abort = !enable;
            end
            WIN_SAMPLE: begin
                busy  = 1'b1;
                abort = !enable || zc_step;
                fire  = enable && !zc_step && (timer_q == ONE);
            end
            default: ;
        endcase
    end

    // R4: an open window always has time left on its timer
    p_timer_live_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_SAMPLE) |-> (timer_q != '0));

    // R10: a window that fires was not aborted in the same cycle
    p_fire_not_aborted_r10: assert property (@(posedge clk) disable iff (rst)
        fire |-> !abort);

    // R8: no window survives a gated cycle
    p_gate_closes_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state_q == WIN_IDLE));

endmodule

// File: rtl/bsd_run_count.sv
module bsd_run_count #(
    parameter int SEL_W   = 2,
    parameter int MAX_RUN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             fire,
    input  logic             is_low,
    input  logic [SEL_W-1:0] run_sel,
    output logic             detect,
    output logic             release_evt
);

    localparam int CNT_W = $clog2(MAX_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, target;

    assign target  = CNT_W'(1) << run_sel;
    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (fire) begin
            cnt_d = is_low ? cnt_inc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign detect      = fire && is_low && !clear && (cnt_inc >= target);
    assign release_evt = fire && !is_low;

    // R3: run count stays within its saturating range
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R2: detection only from a completed low sample
    p_detect_low_r2: assert property (@(posedge clk) disable iff (rst)
        detect |-> (fire && is_low));

    // R6: a non-low sample leaves the count at zero
    p_release_resets_r6: assert property (@(posedge clk) disable iff (rst)
        release_evt |=> (cnt_q == '0));

endmodule

// File: rtl/bsd_status.sv
module bsd_status
    import bsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic detect,
    input  logic release_evt,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic stall_n,
    output logic stall_live,
    output logic stall_latched
);

    stall_state_t state_q, state_d;
    logic         latch_q, latch_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (enable && detect) state_d = ST_STALLED;       // detect
            end
            ST_STALLED: begin
                if (!enable)          state_d = ST_CLEAR;         // gate
                else if (release_evt) state_d = ST_CLEAR;         // release
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        latch_d = latch_q;
        if (enable && detect)             latch_d = 1'b1;
        else if (flag_wr && !flag_wdata)  latch_d = 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            latch_q <= 1'b0;
        end else begin
            state_q <= state_d;
            latch_q <= latch_d;
        end
    end

    // outputs
    always_comb begin
        stall_live = 1'b0;
        unique case (state_q)
            ST_CLEAR:   stall_live = 1'b0;
            ST_STALLED: stall_live = 1'b1;
            default:    stall_live = 1'b0;
        endcase
        stall_n       = !stall_live;
        stall_latched = latch_q;
    end

    // R5: the sticky flag is set whenever the live flag rises
    p_sticky_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_live) |-> stall_latched);

    // R7: the sticky flag only falls after a write of zero
    p_sticky_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_latched) |-> $past(flag_wr && !flag_wdata));

    // R8 / R9: gating clears the live flag
    p_gate_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !stall_live);

    // R11: detection beats a simultaneous clear write
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (enable && detect && flag_wr && !flag_wdata) |=> stall_latched);

endmodule

// File: rtl/bemf_stall_detect.sv
module bemf_stall_detect #(
    parameter int WIN_W   = 8,
    parameter int BEMF_W  = 8,
    parameter int SEL_W   = 2,
    parameter int MAX_RUN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zc_step,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [BEMF_W-1:0] bemf,
    input  logic [BEMF_W-1:0] thresh,
    input  logic [SEL_W-1:0]  run_sel,
    input  logic              ext_mode,
    input  logic              full_step,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic              stall_n,
    output logic              stall_live,
    output logic              stall_latched
);

    logic enable, is_low;
    logic fire, abort, busy;
    logic detect, release_evt;

    assign enable = !ext_mode && !full_step;
    assign is_low = bemf < thresh;

    bsd_window #(.WIN_W(WIN_W)) u_window (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .zc_step (zc_step),
        .win_len (win_len),
        .fire    (fire),
        .abort   (abort),
        .busy    (busy)
    );

    bsd_run_count #(.SEL_W(SEL_W), .MAX_RUN(MAX_RUN)) u_count (
        .clk         (clk),
        .rst         (rst),
        .clear       (abort),
        .fire        (fire),
        .is_low      (is_low),
        .run_sel     (run_sel),
        .detect      (detect),
        .release_evt (release_evt)
    );

    bsd_status u_status (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .detect        (detect),
        .release_evt   (release_evt),
        .flag_wr       (flag_wr),
        .flag_wdata    (flag_wdata),
        .stall_n       (stall_n),
        .stall_live    (stall_live),
        .stall_latched (stall_latched)
    );

    // R1: the pin always mirrors the live flag, including out of reset
    p_pin_matches_r1: assert property (@(posedge clk) disable iff (rst)
        stall_n != stall_live);

    // R4: a sample is only taken from an open window
    p_fire_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        fire |-> busy);

endmodule

// File: tb/bemf_stall_detect_test.sv
module bemf_stall_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int WL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_step = 1'b0;
    logic [7:0] win_len = 8'(WL);
    logic [7:0] bemf = 8'd200;
    logic [7:0] thresh = 8'd100;
    logic [1:0] run_sel = 2'd0;
    logic       ext_mode = 1'b0;
    logic       full_step = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b1;
    logic       stall_n, stall_live, stall_latched;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int  m_busy = 0, m_timer = 0, m_cnt = 0;
    bit  m_live = 0, m_latch = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bemf_stall_detect uut (
        .clk(clk), .rst(rst), .zc_step(zc_step), .win_len(win_len),
        .bemf(bemf), .thresh(thresh), .run_sel(run_sel),
        .ext_mode(ext_mode), .full_step(full_step),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .stall_n(stall_n), .stall_live(stall_live), .stall_latched(stall_latched)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit en, sample, lo, det;
        int wl, need;
        en = !ext_mode && !full_step;
        wl = (win_len == 0) ? 1 : int'(win_len);
        lo = int'(bemf) < int'(thresh);
        need = 1 << run_sel;
        sample = 0;
        det = 0;
        if (rst) begin
            m_busy = 0; m_timer = 0; m_cnt = 0; m_live = 0; m_latch = 0;
        end else begin
            if (!en) begin
                m_busy = 0; m_cnt = 0; m_live = 0;
            end else if (m_busy != 0) begin
                if (zc_step) begin
                    m_timer = wl; m_cnt = 0;
                end else if (m_timer == 1) begin
                    sample = 1; m_busy = 0;
                end else begin
                    m_timer = m_timer - 1;
                end
            end else if (zc_step) begin
                m_busy = 1; m_timer = wl;
            end
            if (sample) begin
                if (lo) begin
                    if (m_cnt < 8) m_cnt = m_cnt + 1;
                    if (m_cnt >= need) det = 1;
                end else begin
                    m_cnt = 0; m_live = 0;
                end
            end
            if (det) begin
                m_live = 1; m_latch = 1;
            end else if (flag_wr && !flag_wdata) begin
                m_latch = 0;
            end
        end
    end

    // compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            checks++;
            if (stall_live !== m_live || stall_n !== !m_live || stall_latched !== m_latch) begin
                errors++;
                $display("FAIL %s model: live=%0b pin=%0b sticky=%0b expected live=%0b pin=%0b sticky=%0b",
                         cur_req, stall_live, stall_n, stall_latched, m_live, !m_live, m_latch);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(negedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    // one zero-current step followed by a full window; returns after results settle
    task automatic zc_pulse(input logic [7:0] v);
        bemf = v;
        zc_step = 1'b1;
        @(negedge clk);
        zc_step = 1'b0;
        repeat (WL) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 pin", stall_n, 1'b1);
        check("R1 live", stall_live, 1'b0);
        check("R1 sticky", stall_latched, 1'b0);

        // R4 / R5: single low step with run_sel=0, exact timing
        cur_req = "R4";
        run_sel = 2'd0;
        bemf = 8'd50;
        zc_step = 1'b1;
        @(negedge clk);
        zc_step = 1'b0;
        repeat (WL - 1) @(negedge clk);
        check("R4 not yet", stall_live, 1'b0);
        @(negedge clk);
        cur_req = "R5";
        check("R5 live", stall_live, 1'b1);
        check("R5 pin", stall_n, 1'b0);
        check("R5 sticky", stall_latched, 1'b1);

        // R6 / R7: release keeps sticky flag
        cur_req = "R6";
        zc_pulse(8'd150);
        check("R6 live", stall_live, 1'b0);
        check("R6 pin", stall_n, 1'b1);
        check("R7 sticky kept", stall_latched, 1'b1);

        // R7: write of one is ignored, write of zero clears
        cur_req = "R7";
        flag_wr = 1'b1; flag_wdata = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0;
        @(negedge clk);
        check("R7 write one", stall_latched, 1'b1);
        flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b1;
        @(negedge clk);
        check("R7 write zero", stall_latched, 1'b0);

        // R2: equal to threshold is not low
        cur_req = "R2";
        zc_pulse(8'd100);
        check("R2 equal", stall_live, 1'b0);
        zc_pulse(8'd99);
        check("R2 below", stall_live, 1'b1);
        zc_pulse(8'd200);

        // R3: run_sel=2 needs four in a row
        cur_req = "R3";
        run_sel = 2'd2;
        for (int i = 0; i < 3; i++) zc_pulse(8'd10);
        check("R3 three of four", stall_live, 1'b0);
        zc_pulse(8'd10);
        check("R3 four of four", stall_live, 1'b1);
        zc_pulse(8'd200);
        zc_pulse(8'd10); zc_pulse(8'd10);
        zc_pulse(8'd200);
        for (int i = 0; i < 3; i++) zc_pulse(8'd10);
        check("R3 run broken", stall_live, 1'b0);
        zc_pulse(8'd10);
        check("R3 run rebuilt", stall_live, 1'b1);
        zc_pulse(8'd200);
        run_sel = 2'd3;
        for (int i = 0; i < 7; i++) zc_pulse(8'd10);
        check("R3 seven of eight", stall_live, 1'b0);
        zc_pulse(8'd10);
        check("R3 eight of eight", stall_live, 1'b1);
        zc_pulse(8'd200);

        // R10: aborted window gives no sample and resets the run
        cur_req = "R10";
        run_sel = 2'd1;
        zc_pulse(8'd10);
        bemf = 8'd10;
        zc_step = 1'b1;
        @(negedge clk);
        zc_step = 1'b0;
        @(negedge clk);
        zc_step = 1'b1;
        @(negedge clk);
        zc_step = 1'b0;
        repeat (WL) @(negedge clk);
        check("R10 abort resets run", stall_live, 1'b0);
        zc_pulse(8'd10);
        check("R10 run after abort", stall_live, 1'b1);

        // R11: clear write in the detection cycle
        cur_req = "R11";
        flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b1;
        check("R11 pre-clear", stall_latched, 1'b0);
        run_sel = 2'd0;
        bemf = 8'd10;
        zc_step = 1'b1;
        @(negedge clk);
        zc_step = 1'b0;
        repeat (WL - 1) @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b1;
        check("R11 set wins", stall_latched, 1'b1);

        // R8: full-step gating
        cur_req = "R8";
        run_sel = 2'd1;
        full_step = 1'b1;
        @(negedge clk);
        check("R8 live gated", stall_live, 1'b0);
        check("R8 pin gated", stall_n, 1'b1);
        zc_pulse(8'd10); zc_pulse(8'd10);
        check("R8 no stall in full step", stall_live, 1'b0);
        full_step = 1'b0;
        zc_pulse(8'd10);
        check("R8 run reset", stall_live, 1'b0);
        zc_pulse(8'd10);
        check("R8 resumes", stall_live, 1'b1);

        // R9: external mode gating, sticky flag kept
        cur_req = "R9";
        ext_mode = 1'b1;
        @(negedge clk);
        check("R9 live gated", stall_live, 1'b0);
        check("R9 pin gated", stall_n, 1'b1);
        check("R9 sticky kept", stall_latched, 1'b1);
        zc_pulse(8'd10); zc_pulse(8'd10);
        check("R9 no stall", stall_live, 1'b0);
        ext_mode = 1'b0;

        // R4: zero window length acts as one
        cur_req = "R4";
        run_sel = 2'd0;
        win_len = 8'd0;
        bemf = 8'd10;
        zc_step = 1'b1;
        @(negedge clk);
        zc_step = 1'b0;
        @(negedge clk);
        check("R4 zero length", stall_live, 1'b1);
        win_len = 8'(WL);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule